// File: doc/BRIEF.md
# Time-Shared FMA Operand Register File

This block is the vector register file of one SIMD unit together with a small sequencer that feeds a three-source fused multiply-add. Each entry is a full vector made of 32-bit lanes. The storage has a single port, so in any cycle it either reads one entry or writes one entry. The sequencer hides this limit behind a fixed four-cycle slot. It reads the first, second and third source in three consecutive cycles. In the fourth cycle it writes the result back to the destination entry.

A client presents a request with three source indices, a destination index and the result vector to be stored. The client holds the request until `ready` is high. When the request is accepted, the sequencer stores the indices and the result vector. It then drives the port through the slot. The three source vectors are captured one per cycle into the A, B and C operand latches. `opnd_valid` pulses for one cycle when all three are present. A new request can be accepted in the write cycle of the current slot, so slots can run back to back with no gap.

The sequencer has five states:
- ST_IDLE
- ST_RD_A
- ST_RD_B
- ST_RD_C
- ST_WR

It has these transitions:
- ST_IDLE to ST_RD_A when a request is accepted.
- ST_IDLE to ST_IDLE when no request is present.
- ST_RD_A to ST_RD_B, always.
- ST_RD_B to ST_RD_C, always.
- ST_RD_C to ST_WR, always.
- ST_WR to ST_RD_A when a request is accepted.
- ST_WR to ST_IDLE when no request is present.

Top module: `vrf_fma_seq`

## Requirements
- R1: After reset the sequencer is in ST_IDLE, `ready` is 1 and `opnd_valid` is 0. Array contents are undefined until they are written.
- R2: A request is accepted on a clock edge where both `req_valid` and `ready` are 1. After acceptance, `ready` is 0 for exactly three cycles (ST_RD_A, ST_RD_B, ST_RD_C) and 1 in the fourth cycle (ST_WR).
- R3: `opnd_valid` is a single-cycle pulse. It is high in the cycle that follows the slot's write cycle.
- R4: While `opnd_valid` is high, the operand outputs carry the stored entries: `opnd_a` holds the entry at `req_src_a`, `opnd_b` the entry at `req_src_b`, and `opnd_c` the entry at `req_src_c`. The indices are the ones captured at acceptance.
- R5: The write cycle stores the `res_data` value sampled at acceptance into the entry named by `req_dst`. Changes to `res_data` after acceptance have no effect on the stored value.
- R6: A request accepted in a write cycle starts its first read in the next cycle. A source equal to the previous slot's destination returns the newly written value.
- R7: While `ready` is 0, `req_valid` and the request fields are ignored. A pending request waits and is taken at the next slot boundary.
- R8: The array performs at most one access per cycle. It reads in each of the three read cycles and writes only in the write cycle, which is a cycle with `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_src_a | input | 8 | Index of the first source entry |
| req_src_b | input | 8 | Index of the second source entry |
| req_src_c | input | 8 | Index of the third source entry |
| req_dst | input | 8 | Index of the destination entry |
| res_data | input | 2048 | Result vector, sampled at acceptance |
| ready | output | 1 | Slot boundary; a request can be taken |
| opnd_a | output | 2048 | First source vector |
| opnd_b | output | 2048 | Second source vector |
| opnd_c | output | 2048 | Third source vector |
| opnd_valid | output | 1 | One-cycle strobe marking a complete operand set |

## Verification
Two events share the write cycle: the write-back of the finishing slot and the acceptance of the next request. The bench provokes this by issuing requests back to back, with a source of each new request equal to the destination just written. A stale value on that operand, or a slot that starts a cycle late, is caught by the reference model on the following `opnd_valid` pulse. The `opnd_valid` pulse of the old slot and the first read of the new slot also coincide. The model judges the pulse timing and the operand values on every clock against its own cycle-level account of the slot.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RD_C,
        ST_WR
    } seq_state_t;
endpackage

// File: rtl/vrf_array.sv
module vrf_array #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 64,
    parameter int LANE_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int WIDTH = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    // one storage column per lane; a read leaves rdata stable through writes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (en) begin
                if (we) cells[addr] <= wdata[g*LANE_W +: LANE_W];
                else    rd_q        <= cells[addr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/vrf_seq_fsm.sv
module vrf_seq_fsm
    import vrf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_src_a,
    input  logic [AW-1:0] req_src_b,
    input  logic [AW-1:0] req_src_c,
    input  logic [AW-1:0] req_dst,
    output logic          ready,
    output logic          take_req,
    output logic          arr_en,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic          cap_a,
    output logic          cap_b,
    output logic          cap_c
);
    seq_state_t state, nxt;
    logic [AW-1:0] idx_a, idx_b, idx_c, idx_d;

    assign ready    = (state == ST_IDLE) || (state == ST_WR);
    assign take_req = ready && req_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = take_req ? ST_RD_A : ST_IDLE;
            ST_RD_A: nxt = ST_RD_B;
            ST_RD_B: nxt = ST_RD_C;
            ST_RD_C: nxt = ST_WR;
            ST_WR:   nxt = take_req ? ST_RD_A : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // slot index capture
    always_ff @(posedge clk) begin
        if (take_req) begin
            idx_a <= req_src_a;
            idx_b <= req_src_b;
            idx_c <= req_src_c;
            idx_d <= req_dst;
        end
    end

    // port and latch control per state
    always_comb begin
        arr_en   = 1'b0;
        arr_we   = 1'b0;
        arr_addr = '0;
        cap_a    = 1'b0;
        cap_b    = 1'b0;
        cap_c    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RD_A: begin
                arr_en   = 1'b1;
                arr_addr = idx_a;
            end
            ST_RD_B: begin
                arr_en   = 1'b1;
                arr_addr = idx_b;
                cap_a    = 1'b1;
            end
            ST_RD_C: begin
                arr_en   = 1'b1;
                arr_addr = idx_c;
                cap_b    = 1'b1;
            end
            ST_WR: begin
                arr_en   = 1'b1;
                arr_we   = 1'b1;
                arr_addr = idx_d;
                cap_c    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vrf_operand_stage.sv
module vrf_operand_stage #(
    parameter int WIDTH = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_req,
    input  logic [WIDTH-1:0] res_in,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic             cap_c,
    input  logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] res_q,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] opnd_c,
    output logic             opnd_valid
);
    always_ff @(posedge clk) begin
        if (take_req) res_q  <= res_in;
        if (cap_a)    opnd_a <= rdata;
        if (cap_b)    opnd_b <= rdata;
        if (cap_c)    opnd_c <= rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) opnd_valid <= 1'b0;
        else        opnd_valid <= cap_c;
    end
endmodule

// File: rtl/vrf_fma_seq.sv
module vrf_fma_seq #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 64,
    parameter int LANE_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int WIDTH = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_src_a,
    input  logic [AW-1:0]    req_src_b,
    input  logic [AW-1:0]    req_src_c,
    input  logic [AW-1:0]    req_dst,
    input  logic [WIDTH-1:0] res_data,
    output logic             ready,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] opnd_c,
    output logic             opnd_valid
);
    logic             take_req, arr_en, arr_we, cap_a, cap_b, cap_c;
    logic [AW-1:0]    arr_addr;
    logic [WIDTH-1:0] rdata, res_q;

    vrf_seq_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .req_src_c(req_src_c),
        .req_dst(req_dst), .ready(ready), .take_req(take_req),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
        .cap_a(cap_a), .cap_b(cap_b), .cap_c(cap_c)
    );

    vrf_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .en(arr_en), .we(arr_we), .addr(arr_addr),
        .wdata(res_q), .rdata(rdata)
    );

    vrf_operand_stage #(.WIDTH(WIDTH)) u_stage (
        .clk(clk), .rst_n(rst_n), .take_req(take_req), .res_in(res_data),
        .cap_a(cap_a), .cap_b(cap_b), .cap_c(cap_c), .rdata(rdata),
        .res_q(res_q), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .opnd_valid(opnd_valid)
    );
endmodule

// File: rtl/vrf_fma_seq_chk.sv
module vrf_fma_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic ready,
    input logic opnd_valid,
    input logic arr_en,
    input logic arr_we
);
    // R2: three busy cycles, boundary in the fourth
    a_r2_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> (!ready ##1 !ready ##1 !ready ##1 ready));

    // R3: strobe lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_valid |=> !opnd_valid);

    // R3: strobe follows the write cycle
    a_r3_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_valid |-> $past(arr_we));

    // R8: writes only at a slot boundary
    a_r8_write_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ready);

    // R8: busy cycles are reads of the single port
    a_r8_busy_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (arr_en && !arr_we));
endmodule

bind vrf_fma_seq vrf_fma_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
    .opnd_valid(opnd_valid), .arr_en(arr_en), .arr_we(arr_we)
);

// File: tb/sim_vrf_fma_seq.sv
module sim_vrf_fma_seq;
    localparam int DEPTH  = 256;
    localparam int LANES  = 64;
    localparam int LANE_W = 32;
    localparam int AW     = 8;
    localparam int W      = LANES * LANE_W;
    localparam int WDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [AW-1:0] req_src_a = '0, req_src_b = '0, req_src_c = '0, req_dst = '0;
    logic [W-1:0] res_data = '0;
    logic         ready, opnd_valid;
    logic [W-1:0] opnd_a, opnd_b, opnd_c;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit live = 1'b0;

    always #2 clk = ~clk;

    vrf_fma_seq #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .req_src_c(req_src_c),
        .req_dst(req_dst), .res_data(res_data), .ready(ready),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .opnd_valid(opnd_valid)
    );

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*LANE_W +: LANE_W] = $urandom;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (low 64 bits)", tag, act[63:0], exp[63:0]);
        end
    endtask

    // behavioural reference: phase 0 idle, 1..4 slot cycles
    logic [W-1:0] mem_m [int];
    int           phase = 0;
    int           m_a, m_b, m_c, m_d, prev_dst = -1;
    logic [W-1:0] m_res, sa, sb, sc, ea, eb, ec;
    bit           ka, kb, kc, ra, rb, rc, eka, ekb, ekc, era, erb, erc;
    bit           exp_valid = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0;
            exp_valid = 1'b0;
        end else begin
            exp_valid = 1'b0;
            unique case (phase)
                1: begin ka = mem_m.exists(m_a); if (ka) sa = mem_m[m_a]; ra = (m_a == prev_dst); end
                2: begin kb = mem_m.exists(m_b); if (kb) sb = mem_m[m_b]; rb = (m_b == prev_dst); end
                3: begin kc = mem_m.exists(m_c); if (kc) sc = mem_m[m_c]; rc = (m_c == prev_dst); end
                4: begin
                    mem_m[m_d] = m_res;
                    prev_dst = m_d;
                    exp_valid = 1'b1;
                    ea = sa; eb = sb; ec = sc;
                    eka = ka; ekb = kb; ekc = kc;
                    era = ra; erb = rb; erc = rc;
                end
                default: ;
            endcase
            if (phase == 0 || phase == 4) begin
                if (req_valid) begin
                    m_a = int'(req_src_a); m_b = int'(req_src_b);
                    m_c = int'(req_src_c); m_d = int'(req_dst);
                    m_res = res_data;
                    phase = 1;
                end else phase = 0;
            end else phase++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && live) begin
            chk(ready == (phase == 0 || phase == 4), "R2 R7 ready",
                W'(ready), W'(phase == 0 || phase == 4));
            chk(opnd_valid == exp_valid, "R3 opnd_valid", W'(opnd_valid), W'(exp_valid));
            if (exp_valid) begin
                if (eka) chk(opnd_a === ea, era ? "R6 opnd_a" : "R4 R5 opnd_a", opnd_a, ea);
                if (ekb) chk(opnd_b === eb, erb ? "R6 opnd_b" : "R4 R5 opnd_b", opnd_b, eb);
                if (ekc) chk(opnd_c === ec, erc ? "R6 opnd_c" : "R4 R5 opnd_c", opnd_c, ec);
            end
        end
    end

    // holds the request through busy cycles (R7), then scrambles res_data (R5)
    task automatic send(int a, int b, int c, int d);
        req_src_a = AW'(a); req_src_b = AW'(b); req_src_c = AW'(c); req_dst = AW'(d);
        res_data  = rnd_vec();
        req_valid = 1'b1;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        res_data  = rnd_vec();
        req_src_a = AW'($urandom); req_src_b = AW'($urandom);
        req_src_c = AW'($urandom); req_dst = AW'($urandom);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d cycles expected=%0d", cycles, WDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(ready === 1'b1, "R1 ready in reset", W'(ready), W'(1));
        chk(opnd_valid === 1'b0, "R1 opnd_valid in reset", W'(opnd_valid), W'(0));
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk);
        chk(ready === 1'b1, "R1 ready after reset", W'(ready), W'(1));
        chk(opnd_valid === 1'b0, "R1 opnd_valid after reset", W'(opnd_valid), W'(0));

        // fill entries, including both index extremes (R5, R8)
        for (int d = 0; d < 8; d++) send(200 + d, 210 + d, 220 + d, d);
        send(230, 231, 232, 255);
        repeat (3) @(negedge clk);

        // distinct patterns (R4)
        send(0, 1, 2, 10);
        send(3, 3, 3, 11);
        send(255, 0, 255, 12);
        // back-to-back reading the just-written entry (R6)
        send(10, 11, 12, 13);
        send(13, 13, 13, 13);
        send(7, 13, 6, 14);
        repeat (5) @(negedge clk);
        // lone request after idle gap
        send(14, 12, 255, 15);
        send(15, 15, 14, 0);
        send(0, 1, 255, 1);
        repeat (8) @(negedge clk);
        finish_run();
    end
endmodule